// File: doc/BRIEF.md
# Port Pin Change Detector

This block watches the upper nibble of an 8-bit general-purpose port for changes. Each time software reads or writes the port, the block takes a snapshot of the synchronised pin levels. From then on, an enabled input pin whose level differs from that snapshot raises a sticky change flag. The flag drives an interrupt request through a global enable.

A mismatch keeps setting the flag on every cycle. Software that only clears the flag therefore sees it return at once. The usual service routine reads the port, which refreshes the snapshot and ends the mismatch, and then clears the flag.

The snapshot is kept through a master or brown-out reset and is loaded again only at power-on. A difference that is still present when a system reset ends raises the flag again straight away.

Top module: `pin_change_monitor`

## Requirements
- R1: Each pin passes through two synchroniser flops. A level driven on `pin_i` appears on `rd_data_o` after two rising clock edges. A change on an enabled monitored pin sets `flag_o` on the third rising edge.
- R2: The flag rises when any monitored pin (bits 7..4) that is enabled differs from the snapshot. Once set, the flag stays set until a clear takes effect, even if the pin returns to its snapshot level.
- R3: While a mismatch is present and no port access happens in the same cycle, `flag_clr_i` does not clear the flag. Setting the flag has priority over clearing it.
- R4: A port read (`rd_stb_i`) or a port write (`wr_stb_i`) loads the snapshot with the current synchronised levels of bits 7..4. A clear strobe in a later cycle then lowers the flag.
- R5: In a cycle with a port access, no new mismatch can set the flag. A change that reaches the synchroniser output in that cycle is absorbed into the snapshot and never raises the flag.
- R6: Bits 3..0 are never monitored. A monitored bit k only takes part when `dir_in_i[k]` is 1 (input) and `ioc_en_i[k-4]` is 1.
- R7: While `sys_rst_n` is low, the flag and the output latch are cleared, port accesses are ignored and the snapshot is kept. On the first rising edge after `sys_rst_n` is released, a mismatch that is still present sets the flag again.
- R8: While `por_n` is low, the flag and the latch are cleared and the snapshot follows the synchronised pins. After `por_n` is released, the flag stays low unless a pin changes.
- R9: `irq_o` is high exactly when the flag is high and `glb_ie_i` is high.
- R10: A write loads `wr_data_i` into `port_lat_o` on the next edge. `rd_data_o` always shows all eight synchronised pin levels.
- R11: A single access refreshes all monitored bits together. A second pin that changes while the flag is already set for a first pin raises no separate event once the read and the clear are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | Master or brown-out reset, active low, synchronous |
| pin_i | input | 8 | Asynchronous pin levels |
| dir_in_i | input | 8 | Pin direction, 1 = input |
| ioc_en_i | input | 4 | Per-pin change enable for bits 7..4 |
| glb_ie_i | input | 1 | Global change-interrupt enable |
| rd_stb_i | input | 1 | Port read strobe |
| wr_stb_i | input | 1 | Port write strobe |
| wr_data_i | input | 8 | Port write data |
| flag_clr_i | input | 1 | Change flag clear strobe |
| rd_data_o | output | 8 | Synchronised pin levels |
| port_lat_o | output | 8 | Last written port value |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Gated change interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit port, a monitored window of four bits starting at bit 4, and two synchroniser stages. This keeps both the ignored lower nibble and the monitored upper nibble in reach, so one pin sequence can show that direction and enable masking gate detection bit by bit. With two stages, the three-edge latency is short enough to line a port access up exactly with the cycle in which a change leaves the synchroniser, which is the absorption corner. Reset sequences cover both the retained snapshot through a system reset and its reload at power-on.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef enum logic [1:0] {
        RST_NONE = 2'd0,
        RST_SYS  = 2'd1,
        RST_POR  = 2'd2
    } rst_kind_e;

    // Power-on reset dominates the system reset.
    function automatic rst_kind_e pcm_rst_kind(input logic por_n, input logic sys_n);
        if (!por_n)      return RST_POR;
        else if (!sys_n) return RST_SYS;
        else             return RST_NONE;
    endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_detect.sv
module pcm_detect #(
    parameter int PORT_W = 8,
    parameter int MON_LO = 4,
    parameter int MON_W  = 4
) (
    input  logic [PORT_W-1:0] pins_i,
    input  logic [PORT_W-1:0] dir_in_i,
    input  logic [MON_W-1:0]  en_i,
    input  logic [MON_W-1:0]  snap_i,
    output logic              mismatch_o
);
    logic [MON_W-1:0] diff_vec;

    for (genvar b = 0; b < MON_W; b++) begin : g_bit
        assign diff_vec[b] = en_i[b] & dir_in_i[MON_LO+b] & (pins_i[MON_LO+b] ^ snap_i[b]);
    end

    assign mismatch_o = |diff_vec;
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor #(
    parameter int PORT_W      = 8,
    parameter int MON_LO      = 4,
    parameter int MON_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] dir_in_i,
    input  logic [MON_W-1:0]  ioc_en_i,
    input  logic              glb_ie_i,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    input  logic [PORT_W-1:0] wr_data_i,
    input  logic              flag_clr_i,
    output logic [PORT_W-1:0] rd_data_o,
    output logic [PORT_W-1:0] port_lat_o,
    output logic              flag_o,
    output logic              irq_o
);
    import pcm_pkg::*;

    localparam int MON_HI = MON_LO + MON_W - 1;

    typedef struct packed {
        logic              flag;
        logic [MON_W-1:0]  snap;
        logic [PORT_W-1:0] lat;
    } pcm_state_t;

    pcm_state_t        st_d, st_q;
    logic [PORT_W-1:0] pin_sync;
    logic [MON_W-1:0]  mon_now;
    logic [MON_W-1:0]  snap_cur;
    logic              mismatch;
    logic              access;
    rst_kind_e         rst_kind;

    pcm_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    pcm_detect #(.PORT_W(PORT_W), .MON_LO(MON_LO), .MON_W(MON_W)) u_detect (
        .pins_i     (pin_sync),
        .dir_in_i   (dir_in_i),
        .en_i       (ioc_en_i),
        .snap_i     (st_q.snap),
        .mismatch_o (mismatch)
    );

    assign mon_now  = pin_sync[MON_HI:MON_LO];
    assign snap_cur = st_q.snap;
    assign access   = rd_stb_i | wr_stb_i;
    assign rst_kind = pcm_rst_kind(por_n, sys_rst_n);

    always_comb begin
        st_d = st_q;
        unique case (rst_kind)
            RST_POR: begin
                st_d.flag = 1'b0;
                st_d.snap = mon_now;
                st_d.lat  = '0;
            end
            RST_SYS: begin
                st_d.flag = 1'b0;
                st_d.lat  = '0;
            end
            default: begin
                if (access)   st_d.snap = mon_now;
                if (wr_stb_i) st_d.lat  = wr_data_i;
                if (mismatch && !access) st_d.flag = 1'b1;
                else if (flag_clr_i)     st_d.flag = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data_o  = pin_sync;
    assign port_lat_o = st_q.lat;
    assign flag_o     = st_q.flag;
    assign irq_o      = st_q.flag & glb_ie_i;
endmodule

// File: rtl/pcm_chk.sv
module pcm_chk #(
    parameter int MON_W = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             rd_stb_i,
    input logic             wr_stb_i,
    input logic             flag_clr_i,
    input logic             glb_ie_i,
    input logic             flag_o,
    input logic             irq_o,
    input logic             mismatch,
    input logic [MON_W-1:0] snap,
    input logic [MON_W-1:0] mon_now
);
    logic acc;
    assign acc = rd_stb_i | wr_stb_i;

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && flag_o && !flag_clr_i) |=> flag_o);

    // R3
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && mismatch && !acc) |=> flag_o);

    // R4
    access_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && acc) |=> (snap == $past(mon_now)));

    // R5
    access_no_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && acc && !flag_o) |=> !flag_o);

    // R7
    sys_rst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> ($stable(snap) && !flag_o));

    // R8
    por_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> !flag_o);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        irq_o |-> (flag_o && glb_ie_i));
endmodule

bind pin_change_monitor pcm_chk #(.MON_W(MON_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .rd_stb_i   (rd_stb_i),
    .wr_stb_i   (wr_stb_i),
    .flag_clr_i (flag_clr_i),
    .glb_ie_i   (glb_ie_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .mismatch   (mismatch),
    .snap       (snap_cur),
    .mon_now    (mon_now)
);

// File: tb/pin_change_monitor_tb.sv
module pin_change_monitor_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic [7:0] pin_i = 8'hA0;
    logic [7:0] dir_in_i = 8'hFF;
    logic [3:0] ioc_en_i = 4'hF;
    logic       glb_ie_i = 1'b1;
    logic       rd_stb_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       flag_clr_i = 1'b0;
    logic [7:0] rd_data_o, port_lat_o;
    logic       flag_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_change_monitor u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .pin_i(pin_i),
        .dir_in_i(dir_in_i), .ioc_en_i(ioc_en_i), .glb_ie_i(glb_ie_i),
        .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i),
        .flag_clr_i(flag_clr_i), .rd_data_o(rd_data_o), .port_lat_o(port_lat_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [7:0] m_pipe [$];
    logic [3:0] m_snap = 4'h0;
    logic       m_flag = 1'b0;
    logic [7:0] m_lat  = 8'h00;

    initial begin
        m_pipe.push_back(8'h00);
        m_pipe.push_back(8'h00);
    end

    always @(posedge clk) begin
        logic [7:0] seen;
        bit diff;
        cyc++;
        seen = m_pipe[0];
        if (!por_n) begin
            m_snap = seen[7:4]; m_flag = 1'b0; m_lat = 8'h00;
        end else if (!sys_rst_n) begin
            m_flag = 1'b0; m_lat = 8'h00;
        end else begin
            diff = 1'b0;
            for (int k = 4; k < 8; k++)
                if (ioc_en_i[k-4] && dir_in_i[k] && (seen[k] != m_snap[k-4])) diff = 1'b1;
            if (wr_stb_i) m_lat = wr_data_i;
            if (rd_stb_i || wr_stb_i) m_snap = seen[7:4];
            if (diff && !(rd_stb_i || wr_stb_i)) m_flag = 1'b1;
            else if (flag_clr_i) m_flag = 1'b0;
        end
        void'(m_pipe.pop_front());
        m_pipe.push_back(pin_i);
        #5;
        if (por_n && cyc > 4) begin
            check("R2 flag vs model", {7'd0, flag_o}, {7'd0, m_flag});
            check("R9 irq vs model", {7'd0, irq_o}, {7'd0, m_flag & glb_ie_i});
            check("R10 rd_data vs model", rd_data_o, m_pipe[0]);
            check("R10 latch vs model", port_lat_o, m_lat);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_stb_i = 1'b1; tick(1); rd_stb_i = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(6);
        por_n = 1'b1;
        tick(3);
        // R8: snapshot taken during power-on reset, pins A0 give no flag
        check("R8 flag after POR", {7'd0, flag_o}, 8'd0);
        check("R10 rd_data reset", rd_data_o, 8'hA0);

        // R6: lower nibble, output-direction and disabled bits ignored
        pin_i = 8'hAF; tick(5);
        check("R6 lower nibble", {7'd0, flag_o}, 8'd0);
        dir_in_i = 8'hEF; pin_i = 8'hBF; tick(5);
        check("R6 output dir", {7'd0, flag_o}, 8'd0);
        ioc_en_i = 4'hD; pin_i = 8'h9F; tick(5);
        check("R6 disabled bit", {7'd0, flag_o}, 8'd0);
        pin_i = 8'hAF; tick(4);
        dir_in_i = 8'hFF; ioc_en_i = 4'hF; tick(4);
        check("R6 restored", {7'd0, flag_o}, 8'd0);

        // R1: latency through the synchroniser and the flag register
        pin_i = 8'h2F; tick(2);
        check("R1 rd_data after two edges", rd_data_o, 8'h2F);
        check("R1 flag not yet", {7'd0, flag_o}, 8'd0);
        tick(1);
        check("R1 flag third edge", {7'd0, flag_o}, 8'd1);
        check("R9 irq with enable", {7'd0, irq_o}, 8'd1);

        // R2: sticky after pin returns
        pin_i = 8'hAF; tick(5);
        check("R2 sticky", {7'd0, flag_o}, 8'd1);

        // R3: clear loses to a live mismatch
        pin_i = 8'h2F; tick(4);
        pulse_clr(); tick(1);
        check("R3 clear ignored", {7'd0, flag_o}, 8'd1);

        // R4: read reloads snapshot, then clear works
        pulse_rd(); pulse_clr(); tick(1);
        check("R4 read then clear", {7'd0, flag_o}, 8'd0);

        // R9: global gate
        pin_i = 8'hAF; tick(4);
        glb_ie_i = 1'b0; tick(1);
        check("R9 irq gated", {7'd0, irq_o}, 8'd0);
        check("R9 flag kept", {7'd0, flag_o}, 8'd1);
        glb_ie_i = 1'b1;
        pulse_rd(); pulse_clr(); tick(1);

        // R5: change reaches the comparator in the read cycle
        pin_i = 8'h2F; tick(2);
        pulse_rd(); tick(4);
        check("R5 absorbed change", {7'd0, flag_o}, 8'd0);

        // R7: system reset keeps snapshot and re-flags
        pin_i = 8'hAF; tick(4);
        sys_rst_n = 1'b0; rd_stb_i = 1'b1; tick(3);
        check("R7 flag during sys reset", {7'd0, flag_o}, 8'd0);
        rd_stb_i = 1'b0; sys_rst_n = 1'b1; tick(1);
        check("R7 flag after release", {7'd0, flag_o}, 8'd1);
        pulse_rd(); pulse_clr(); tick(1);

        // R11: second pin changes while first is serviced
        pin_i = 8'h2F; tick(4);
        check("R11 first event", {7'd0, flag_o}, 8'd1);
        pin_i = 8'h0F; tick(3);
        pulse_rd(); pulse_clr(); tick(3);
        check("R11 second change lost", {7'd0, flag_o}, 8'd0);

        // R10 + R4: write loads latch and refreshes snapshot
        pin_i = 8'h8F; tick(4);
        wr_data_i = 8'h5A; wr_stb_i = 1'b1; tick(1); wr_stb_i = 1'b0;
        check("R10 latch write", port_lat_o, 8'h5A);
        pulse_clr(); tick(1);
        check("R4 write then clear", {7'd0, flag_o}, 8'd0);

        // R8: power-on reset mid-run reloads snapshot
        pin_i = 8'h4F; tick(4);
        por_n = 1'b0; tick(3);
        por_n = 1'b1; tick(3);
        check("R8 flag after second POR", {7'd0, flag_o}, 8'd0);
        check("R8 latch cleared", port_lat_o, 8'h00);

        tick(2);
        finish_run();
    end
endmodule